// File: doc/BRIEF.md
# Copier Cartridge Bank Mapping Controller

This block decides which external memory bank answers each CPU and PPU address window of a RAM-cartridge copier. The CPU programs it over a plain write bus. A primary mode register sets the bank layout, the mirroring and the latch enable. A secondary mode register chooses between the latch-driven layouts and four directly written 8 KiB PRG bank registers. A data latch is loaded by writes to the upper half of the CPU space.

The outputs are four 8 KiB PRG bank numbers (one per CPU slot at 8000, A000, C000 and E000), one 8 KiB CHR bank number, a two-bit nametable mirroring code and two write-enable levels. The external PRG and CHR memories use these as address extension bits and write gates. All outputs are decoded from register state alone.

Top module: `copier_map_ctrl`

## Requirements
- R1: After reset the primary mode register holds MODE_A_INIT, the secondary register's map-select bit holds MODE_B_INIT bit 0, and the latch is 0. The direct PRG registers for slots 0..3 hold PRG_BANKS-4, PRG_BANKS-3, PRG_BANKS-2 and PRG_BANKS-1. With the defaults (0x22, 0x01, 64 banks) the PRG slots read 0, 1, 14, 15, the CHR bank reads 0, mirroring reads 0, PRG write-enable is 0 and CHR write-enable is 1.
- R2: A write to any address MODE_A_BASE..MODE_A_BASE+3 stores data[7:4] as mode bits 7:4 and address bits 1:0 as mode bits 1:0. The layout field is mode bits 7:5, mirroring page/orientation is bit 4, latch enable is bit 1, and dual-screen is bit 0. Writes to addresses outside the group leave the outputs unchanged.
- R3: A write to any address MODE_B_BASE..MODE_B_BASE+3 loads the latch with the written data and sets the map-select bit to address bit 0. This happens whatever the latch-enable bit holds.
- R4: While latch enable is 1, a write to 8000-FFFF loads the latch. While it is 0, such writes leave the latch unchanged and prg_we_o is 1. Writes below 8000 never load the latch.
- R5: With map-select 1, layouts 0 to 3 map two 16 KiB banks (lower, upper). Layout 0 gives latch[2:0] and 7. Layout 1 gives latch[5:2] and 7. Layout 2 gives latch[3:0] and 15. Layout 3 gives 15 and latch[3:0]. A 16 KiB bank b occupies 8 KiB slots 2b and 2b+1.
- R6: With map-select 1, layout 4 maps 32 KiB bank latch[5:4], and layouts 5, 6 and 7 map 32 KiB bank 3. A 32 KiB bank b fills the four slots with 4b, 4b+1, 4b+2, 4b+3.
- R7: chr_bank_o is 0 in layouts 0 and 2, latch[1:0] in layouts 1, 4 and 5, latch[5:4] in layout 3, latch[0] in layout 6 and 3 in layout 7.
- R8: mirror_o is 0 for single-screen page 0, 1 for single-screen page 1, 2 for vertical and 3 for horizontal. When dual-screen is 0, bit 4 picks the page. When dual-screen is 1, bit 4 picks horizontal (1) or vertical (0).
- R9: chr_we_o is 0 exactly when the primary mode byte ANDed with 0xE1 is at least 0x81.
- R10: With map-select 0, slot k is driven by direct PRG register k. A write to PRG_REG_BASE+k stores the low PRG bank-width bits of the data into register k.
- R11: A new register value shows on all bank outputs in the cycle that follows the write's clock edge, with no further pipeline delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | CPU write strobe, one cycle per write |
| wr_addr_i | input | 16 | CPU write address |
| wr_data_i | input | 8 | CPU write data |
| prg_bank_o | output | 4*PRG_BANK_W | 8 KiB PRG bank per slot; slot k at bits [k*PRG_BANK_W +: PRG_BANK_W] |
| chr_bank_o | output | CHR_BANK_W | 8 KiB CHR bank number |
| mirror_o | output | 2 | Nametable mirroring code |
| prg_we_o | output | 1 | PRG memory accepts CPU writes to 8000-FFFF |
| chr_we_o | output | 1 | CHR memory accepts PPU writes |

## Verification
On every cycle, the assertions check the register side: the mode fields follow the write that hit them, the latch follows the secondary-mode group and the enabled upper-space writes, and the latch holds while the enable is clear. They also check the structure of the outputs: paired 16 KiB slots, contiguous 32 KiB slots, the orientation bit under dual-screen, and an open CHR write gate in layouts 0 to 3. Whether each layout slices the latch into the right bank numbers and CHR bank, and whether the write-protect threshold sits exactly at 0x81, is shown only by the bench scenarios. Those scenarios go through all eight layouts with two latch patterns, all four mirroring codes, the protect boundary and the switch to the direct PRG registers.

// File: rtl/ccm_pkg.sv
package ccm_pkg;

  typedef enum logic [1:0] {
    MIR_PAGE0 = 2'd0,
    MIR_PAGE1 = 2'd1,
    MIR_VERT  = 2'd2,
    MIR_HORZ  = 2'd3
  } mirror_e;

  typedef struct packed {
    logic [2:0] layout;
    logic       page_sel;
    logic       latch_en;
    logic       dual_scr;
  } mode_a_t;

  localparam int LATCH_W = 6;

  function automatic logic [7:0] mode_a_byte(mode_a_t m);
    return {m.layout, m.page_sel, 2'b00, m.latch_en, m.dual_scr};
  endfunction

endpackage

// File: rtl/ccm_regs.sv
module ccm_regs
  import ccm_pkg::*;
#(
  parameter int          PRG_BANKS    = 64,
  parameter int          PRG_BANK_W   = 6,
  parameter logic [7:0]  MODE_A_INIT  = 8'h22,
  parameter logic [7:0]  MODE_B_INIT  = 8'h01,
  parameter logic [15:0] MODE_A_BASE  = 16'h42FC,
  parameter logic [15:0] MODE_B_BASE  = 16'h43FC,
  parameter logic [15:0] PRG_REG_BASE = 16'h4504
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [15:0]                wr_addr_i,
  input  logic [7:0]                 wr_data_i,
  output mode_a_t                    mode_a_o,
  output logic                       map_sel_o,
  output logic [LATCH_W-1:0]         latch_o,
  output logic [3:0][PRG_BANK_W-1:0] prg_reg_o
);

  localparam logic [13:0] A_TAG = MODE_A_BASE[15:2];
  localparam logic [13:0] B_TAG = MODE_B_BASE[15:2];
  localparam logic [13:0] P_TAG = PRG_REG_BASE[15:2];
  localparam mode_a_t     A_RST = '{layout:   MODE_A_INIT[7:5],
                                    page_sel: MODE_A_INIT[4],
                                    latch_en: MODE_A_INIT[1],
                                    dual_scr: MODE_A_INIT[0]};

  logic a_hit, b_hit, p_hit, l_hit;
  mode_a_t            mode_a_q;
  logic               map_sel_q;
  logic [LATCH_W-1:0] latch_q;

  assign a_hit = wr_en_i && (wr_addr_i[15:2] == A_TAG);
  assign b_hit = wr_en_i && (wr_addr_i[15:2] == B_TAG);
  assign p_hit = wr_en_i && (wr_addr_i[15:2] == P_TAG);
  assign l_hit = wr_en_i && wr_addr_i[15] && mode_a_q.latch_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_a_q <= A_RST;
    end else if (a_hit) begin
      mode_a_q <= '{layout:   wr_data_i[7:5],
                    page_sel: wr_data_i[4],
                    latch_en: wr_addr_i[1],
                    dual_scr: wr_addr_i[0]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_sel_q <= MODE_B_INIT[0];
    end else if (b_hit) begin
      map_sel_q <= wr_addr_i[0];
    end
  end

  // secondary mode group and enabled upper-space writes both feed the latch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
    end else if (b_hit || l_hit) begin
      latch_q <= wr_data_i[LATCH_W-1:0];
    end
  end

  for (genvar i = 0; i < 4; i++) begin : g_prg
    localparam logic [PRG_BANK_W-1:0] P_RST = PRG_BANK_W'(PRG_BANKS - 4 + i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prg_reg_o[i] <= P_RST;
      end else if (p_hit && (wr_addr_i[1:0] == 2'(i))) begin
        prg_reg_o[i] <= PRG_BANK_W'(wr_data_i);
      end
    end
  end

  assign mode_a_o  = mode_a_q;
  assign map_sel_o = map_sel_q;
  assign latch_o   = latch_q;

  p_mode_fields_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_hit |=> (mode_a_q.layout == $past(wr_data_i[7:5]) &&
               mode_a_q.page_sel == $past(wr_data_i[4]) &&
               mode_a_q.latch_en == $past(wr_addr_i[1]) &&
               mode_a_q.dual_scr == $past(wr_addr_i[0])));

  p_latch_mode_b_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_hit |=> (latch_q == $past(wr_data_i[LATCH_W-1:0]) && map_sel_q == $past(wr_addr_i[0])));

  p_latch_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!b_hit && !(wr_en_i && wr_addr_i[15] && mode_a_q.latch_en)) |=> $stable(latch_q));

  p_prg_reg_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_hit |=> prg_reg_o[$past(wr_addr_i[1:0])] == $past(PRG_BANK_W'(wr_data_i)));

endmodule

// File: rtl/ccm_prg_map.sv
module ccm_prg_map
  import ccm_pkg::*;
#(
  parameter int PRG_BANK_W = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [2:0]                 layout_i,
  input  logic                       map_sel_i,
  input  logic [LATCH_W-1:0]         latch_i,
  input  logic [3:0][PRG_BANK_W-1:0] prg_reg_i,
  output logic [3:0][PRG_BANK_W-1:0] slot_o
);

  logic [3:0] lo16, hi16;
  logic [1:0] bank32;
  logic       use32;

  always_comb begin
    lo16   = 4'd0;
    hi16   = 4'd0;
    bank32 = 2'd3;
    use32  = 1'b0;
    case (layout_i)
      3'd0: begin lo16 = {1'b0, latch_i[2:0]}; hi16 = 4'd7;  end
      3'd1: begin lo16 = latch_i[5:2];         hi16 = 4'd7;  end
      3'd2: begin lo16 = latch_i[3:0];         hi16 = 4'd15; end
      3'd3: begin lo16 = 4'd15;                hi16 = latch_i[3:0]; end
      3'd4: begin use32 = 1'b1; bank32 = latch_i[5:4]; end
      default: begin use32 = 1'b1; bank32 = 2'd3; end
    endcase
  end

  for (genvar k = 0; k < 4; k++) begin : g_slot
    logic [3:0] half;
    assign half = (k < 2) ? lo16 : hi16;
    always_comb begin
      if (!map_sel_i)  slot_o[k] = prg_reg_i[k];
      else if (use32)  slot_o[k] = PRG_BANK_W'({bank32, 2'(k)});
      else             slot_o[k] = PRG_BANK_W'({half, 1'(k % 2)});
    end
  end

  p_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (map_sel_i && !layout_i[2]) |->
      (!slot_o[0][0] && slot_o[1] == (slot_o[0] | PRG_BANK_W'(1)) &&
       !slot_o[2][0] && slot_o[3] == (slot_o[2] | PRG_BANK_W'(1))));

  p_quad_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (map_sel_i && layout_i[2]) |->
      (slot_o[0][1:0] == 2'd0 && slot_o[3] == slot_o[0] + PRG_BANK_W'(3)));

endmodule

// File: rtl/ccm_chr_map.sv
module ccm_chr_map
  import ccm_pkg::*;
#(
  parameter int CHR_BANK_W = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  mode_a_t               mode_a_i,
  input  logic [1:0]            lat_lo_i,
  input  logic [1:0]            lat_hi_i,
  output logic [CHR_BANK_W-1:0] chr_bank_o,
  output mirror_e               mirror_o,
  output logic                  chr_we_o
);

  logic [1:0] bank;

  always_comb begin
    case (mode_a_i.layout)
      3'd1, 3'd4, 3'd5: bank = lat_lo_i;
      3'd3:             bank = lat_hi_i;
      3'd6:             bank = {1'b0, lat_lo_i[0]};
      3'd7:             bank = 2'd3;
      default:          bank = 2'd0;
    endcase
  end

  assign chr_bank_o = CHR_BANK_W'(bank);

  always_comb begin
    if (mode_a_i.dual_scr) mirror_o = mode_a_i.page_sel ? MIR_HORZ  : MIR_VERT;
    else                   mirror_o = mode_a_i.page_sel ? MIR_PAGE1 : MIR_PAGE0;
  end

  assign chr_we_o = !((mode_a_byte(mode_a_i) & 8'hE1) >= 8'h81);

  p_chr_open_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_a_i.layout[2] |-> chr_we_o);

  p_orient_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_a_i.dual_scr |-> mirror_o[1]);

  p_chr_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_a_i.layout == 3'd0 || mode_a_i.layout == 3'd2) |-> (chr_bank_o == '0));

endmodule

// File: rtl/copier_map_ctrl.sv
module copier_map_ctrl
  import ccm_pkg::*;
#(
  parameter int          PRG_BANKS    = 64,
  parameter int          CHR_BANK_W   = 2,
  parameter logic [7:0]  MODE_A_INIT  = 8'h22,
  parameter logic [7:0]  MODE_B_INIT  = 8'h01,
  parameter logic [15:0] MODE_A_BASE  = 16'h42FC,
  parameter logic [15:0] MODE_B_BASE  = 16'h43FC,
  parameter logic [15:0] PRG_REG_BASE = 16'h4504,
  localparam int         PRG_BANK_W   = $clog2(PRG_BANKS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [15:0]             wr_addr_i,
  input  logic [7:0]              wr_data_i,
  output logic [4*PRG_BANK_W-1:0] prg_bank_o,
  output logic [CHR_BANK_W-1:0]   chr_bank_o,
  output logic [1:0]              mirror_o,
  output logic                    prg_we_o,
  output logic                    chr_we_o
);

  mode_a_t                    mode_a;
  logic                       map_sel;
  logic [LATCH_W-1:0]         latch;
  logic [3:0][PRG_BANK_W-1:0] prg_reg;
  logic [3:0][PRG_BANK_W-1:0] slot;
  mirror_e                    mirror;

  ccm_regs #(
    .PRG_BANKS   (PRG_BANKS),
    .PRG_BANK_W  (PRG_BANK_W),
    .MODE_A_INIT (MODE_A_INIT),
    .MODE_B_INIT (MODE_B_INIT),
    .MODE_A_BASE (MODE_A_BASE),
    .MODE_B_BASE (MODE_B_BASE),
    .PRG_REG_BASE(PRG_REG_BASE)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .mode_a_o (mode_a),
    .map_sel_o(map_sel),
    .latch_o  (latch),
    .prg_reg_o(prg_reg)
  );

  ccm_prg_map #(.PRG_BANK_W(PRG_BANK_W)) u_prg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .layout_i (mode_a.layout),
    .map_sel_i(map_sel),
    .latch_i  (latch),
    .prg_reg_i(prg_reg),
    .slot_o   (slot)
  );

  ccm_chr_map #(.CHR_BANK_W(CHR_BANK_W)) u_chr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_a_i  (mode_a),
    .lat_lo_i  (latch[1:0]),
    .lat_hi_i  (latch[5:4]),
    .chr_bank_o(chr_bank_o),
    .mirror_o  (mirror),
    .chr_we_o  (chr_we_o)
  );

  assign prg_bank_o = slot;
  assign mirror_o   = mirror;
  assign prg_we_o   = !mode_a.latch_en;

endmodule

// File: tb/sim_copier_map_ctrl.sv
`timescale 1ns/1ps
module sim_copier_map_ctrl;

  localparam int PW = 6;

  typedef struct {
    string tag;
    int s0, s1, s2, s3, chr, mir, pwe, cwe;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [15:0]   wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [4*PW-1:0] prg_bank;
  logic [1:0]    chr_bank;
  logic [1:0]    mirror;
  logic          prg_we, chr_we;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  exp_t q[$];

  // reference state built from the requirements
  int m_layout = 1, m_page = 0, m_len = 1, m_dual = 0, m_map = 1, m_latch = 0;
  int m_prg[4] = '{60, 61, 62, 63};

  always #10 clk = ~clk;

  copier_map_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .prg_bank_o(prg_bank), .chr_bank_o(chr_bank),
    .mirror_o(mirror), .prg_we_o(prg_we), .chr_we_o(chr_we)
  );

  function automatic exp_t predict(string tag);
    exp_t e;
    int lo, hi, b, mb;
    bit big;
    e.tag = tag;
    lo = 0; hi = 0; b = 3; big = 0;
    case (m_layout)
      0: begin lo = m_latch & 7;        hi = 7;  end
      1: begin lo = (m_latch >> 2) & 15; hi = 7; end
      2: begin lo = m_latch & 15;       hi = 15; end
      3: begin lo = 15;                 hi = m_latch & 15; end
      4: begin big = 1; b = (m_latch >> 4) & 3; end
      default: begin big = 1; b = 3; end
    endcase
    if (m_map == 0) begin
      e.s0 = m_prg[0]; e.s1 = m_prg[1]; e.s2 = m_prg[2]; e.s3 = m_prg[3];
    end else if (big) begin
      e.s0 = 4*b; e.s1 = 4*b + 1; e.s2 = 4*b + 2; e.s3 = 4*b + 3;
    end else begin
      e.s0 = 2*lo; e.s1 = 2*lo + 1; e.s2 = 2*hi; e.s3 = 2*hi + 1;
    end
    case (m_layout)
      1, 4, 5: e.chr = m_latch & 3;
      3:       e.chr = (m_latch >> 4) & 3;
      6:       e.chr = m_latch & 1;
      7:       e.chr = 3;
      default: e.chr = 0;
    endcase
    e.mir = m_dual ? (m_page ? 3 : 2) : (m_page ? 1 : 0);
    e.pwe = m_len ? 0 : 1;
    mb = (m_layout << 5) | (m_page << 4) | (m_len << 1) | m_dual;
    e.cwe = ((mb & 8'hE1) >= 8'h81) ? 0 : 1;
    return e;
  endfunction

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    if (a[15:2] == 14'h10BF) begin
      m_layout = d[7:5]; m_page = d[4]; m_len = a[1]; m_dual = a[0];
    end
    if (a[15:2] == 14'h10FF) begin
      m_map = a[0]; m_latch = d;
    end
    if (a[15:2] == 14'h1141) m_prg[a[1:0]] = d & 63;
    if (a[15] && m_len != 0) m_latch = d;
    q.push_back(predict(tag));
  endtask

  // monitor: one expected item per cycle, compared away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        int a0, a1, a2, a3;
        e = q.pop_front();
        a0 = int'(prg_bank[0*PW +: PW]); a1 = int'(prg_bank[1*PW +: PW]);
        a2 = int'(prg_bank[2*PW +: PW]); a3 = int'(prg_bank[3*PW +: PW]);
        compared++;
        if (a0 != e.s0 || a1 != e.s1 || a2 != e.s2 || a3 != e.s3 ||
            int'(chr_bank) != e.chr || int'(mirror) != e.mir ||
            int'(prg_we) != e.pwe || int'(chr_we) != e.cwe) begin
          mismatched++;
          $display("FAIL %s: actual prg=%0d,%0d,%0d,%0d chr=%0d mir=%0d pwe=%0d cwe=%0d expected prg=%0d,%0d,%0d,%0d chr=%0d mir=%0d pwe=%0d cwe=%0d",
                   e.tag, a0, a1, a2, a3, chr_bank, mirror, prg_we, chr_we,
                   e.s0, e.s1, e.s2, e.s3, e.chr, e.mir, e.pwe, e.cwe);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual run still busy expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    q.push_back(predict("R1 reset state"));

    // R5 R6 R7: every layout with two latch patterns (latch enabled via address bit 1)
    for (int m = 0; m < 8; m++) begin
      wr(16'h42FE, 8'(m << 5), "R2 layout select");
      wr(16'h8000, 8'hB6, "R5 R6 R7 latch pattern B6");
      wr(16'hE001, 8'h49, "R5 R6 R7 latch pattern 49");
    end

    // R8: four mirroring codes
    wr(16'h42FC, 8'h30, "R8 single page 1");
    wr(16'h42FD, 8'h10, "R8 horizontal");
    wr(16'h42FD, 8'h00, "R8 vertical");
    wr(16'h42FC, 8'h00, "R8 single page 0");

    // R4: latch disabled, upper-space write is ignored
    wr(16'h8000, 8'h3F, "R4 latch ignored while disabled");
    wr(16'h42FE, 8'h40, "R4 latch unchanged after enable");
    wr(16'h7FFF, 8'h12, "R4 write below 8000 ignored");
    wr(16'h42FB, 8'hFF, "R2 address outside mode group");

    // R9: protect threshold
    wr(16'h42FF, 8'hA0, "R9 protect layout5 bit0");
    wr(16'h42FE, 8'h80, "R9 open layout4 bit0 clear");
    wr(16'h42FF, 8'h80, "R9 protect at 0x81 boundary");
    wr(16'h42FF, 8'h60, "R9 open layout3");

    // R3: secondary mode group loads latch
    wr(16'h43FD, 8'h2C, "R3 latch from mode b");

    // R10: direct PRG registers
    wr(16'h43FE, 8'h07, "R10 direct registers reset values");
    wr(16'h4504, 8'h05, "R10 slot0 write");
    wr(16'h4505, 8'h11, "R10 slot1 write");
    wr(16'h4506, 8'h2A, "R10 slot2 write");
    wr(16'h4507, 8'h3F, "R10 slot3 write");
    wr(16'h43FF, 8'h10, "R11 back to latch layout next cycle");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule